// File: doc/BRIEF.md
# Return Stack with Interrupt Gating

This block keeps the return addresses of a small 8-bit processor core. A subroutine call pushes the current program-counter value. Entering an interrupt also pushes it. A return or a return-from-interrupt pops the most recent address, and that address is on the output in the same cycle as the pop. Storage is a circular buffer of six entries with an occupancy count of 0 to 6. A call made while all six slots are in use still succeeds: the oldest address is overwritten, so the six newest remain.

The block also decides when an interrupt may be taken. A request is latched in a pending flag. The acknowledge is only given when the stack has a free slot, so an interrupt can never push past the top. While the stack is full the request stays pending. It is acknowledged in the first free cycle after a return has made room. The acknowledge pushes the interrupt return address in the same cycle. Instruction decode and the program counter live in the core.

Top module: `ret_stack_irq_gate`

## Requirements
- R1: After reset the stack is empty (`empty_o`=1, `full_o`=0), no request is pending, and `irq_ack_o` stays 0 while `irq_en_i` is high and no request has arrived.
- R2: `call_i` pushes `pc_i`. `ret_i` pops the most recently pushed address, and that address is on `ret_addr_o` combinationally in the same cycle as the pop (last in, first out).
- R3: The occupancy runs from 0 to DEPTH (6 by default). `full_o` is 1 exactly at DEPTH and `empty_o` is 1 exactly at 0.
- R4: A call on a full stack overwrites the oldest entry and leaves the stack full. Later pops return the DEPTH most recent addresses, newest first.
- R5: A pop on a non-empty stack lowers the occupancy by one. A pop on an empty stack leaves it at zero and drives `underflow_o` high in that same cycle. `underflow_o` is 0 in every other cycle.
- R6: A one-cycle high on `irq_req_i` sets the pending flag from the next cycle on. `irq_ack_o` is high only when the flag is set, `irq_en_i` is 1, the stack is not full, and neither `call_i` nor `ret_i` is high in that cycle.
- R7: `irq_ack_o` is a single-cycle pulse. In that cycle it clears the pending flag and pushes `pc_i` as the interrupt return address. If `irq_req_i` is high in the acknowledge cycle, the flag is set again.
- R8: A request that arrives while the stack is full stays pending. It is acknowledged in the first cycle after a pop that has neither a call nor a pop.
- R9: `call_i` and `ret_i` high in the same cycle put the current top on `ret_addr_o` and replace it with `pc_i`, leaving the occupancy unchanged. On an empty stack they raise `underflow_o` and leave `pc_i` as the single entry.
- R10: A request that arrives while `irq_en_i` is 0 stays pending and is acknowledged once `irq_en_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Subroutine call: push `pc_i` |
| ret_i | input | 1 | Return or return-from-interrupt: pop |
| pc_i | input | ADDR_W | Return address pushed by a call or an acknowledge |
| irq_req_i | input | 1 | Interrupt request pulse, latched as pending |
| irq_en_i | input | 1 | Interrupt enable; 0 masks the acknowledge |
| ret_addr_o | output | ADDR_W | Top-of-stack address, valid during a pop of a non-empty stack |
| irq_ack_o | output | 1 | Interrupt acknowledge pulse |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |
| underflow_o | output | 1 | Pop attempted on an empty stack |

## Verification
Some properties are checked on every cycle:
- the acknowledge never fires on a full stack, with interrupts disabled, or in a call or pop cycle;
- full and empty are never high together;
- the occupancy never leaves its range;
- a call on a full stack keeps it full;
- a lone pop on an empty stack keeps it empty and flags underflow.

Other properties depend on stored values and on event order, so only the bench's reference queue can show them. These are the order of the returned addresses after an overflow, the replace-top result of a simultaneous call and pop, and the exact cycle in which a held-off request is finally acknowledged.

// File: rtl/rs_pkg.sv
package rs_pkg;

   // Operation applied to the stack in one cycle
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_POP  = 2'b01,
      OP_PUSH = 2'b10,
      OP_SWAP = 2'b11
   } stack_op_e;

   function automatic stack_op_e op_decode(input logic push, input logic pop);
      return stack_op_e'({push, pop});
   endfunction

endpackage

// File: rtl/rs_store.sv
module rs_store #(
   parameter int unsigned ADDR_W         = 11,
   parameter int unsigned DEPTH          = 6,
   parameter bit          CLEAR_ON_RESET = 1'b1,
   localparam int unsigned PTR_W         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_idx_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_data_o
);

   logic [ADDR_W-1:0] slot_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic hit;
      assign hit = wr_en_i && (wr_idx_i == PTR_W'(gi));
      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[gi] <= '0;
            end else if (hit) begin
               slot_q[gi] <= wr_data_i;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) begin
               slot_q[gi] <= wr_data_i;
            end
         end
         logic unused_rst;
         assign unused_rst = rst_n;
      end
   end

   assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
   import rs_pkg::*;
#(
   parameter int unsigned DEPTH  = 6,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_idx_o,
   output logic [PTR_W-1:0] rd_idx_o,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o,
   output logic             empty_o,
   output logic             underflow_o
);

   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

   function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] x);
      return (x == LAST_IDX) ? '0 : x + 1'b1;
   endfunction

   function automatic logic [PTR_W-1:0] wrap_dec(input logic [PTR_W-1:0] x);
      return (x == '0) ? LAST_IDX : x - 1'b1;
   endfunction

   logic [PTR_W-1:0] wptr_q, wptr_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [PTR_W-1:0] top_idx;
   stack_op_e        op;

   assign op      = op_decode(push_i, pop_i);
   assign top_idx = wrap_dec(wptr_q);
   assign full_o  = (cnt_q == CNT_MAX);
   assign empty_o = (cnt_q == '0);

   always_comb begin
      wptr_d      = wptr_q;
      cnt_d       = cnt_q;
      wr_en_o     = 1'b0;
      wr_idx_o    = wptr_q;
      underflow_o = 1'b0;
      unique case (op)
         OP_PUSH: begin
            // when full, wptr_q addresses the oldest slot: overwrite it
            wr_en_o = 1'b1;
            wptr_d  = wrap_inc(wptr_q);
            cnt_d   = full_o ? cnt_q : cnt_q + 1'b1;
         end
         OP_POP: begin
            if (empty_o) begin
               underflow_o = 1'b1;
            end else begin
               wptr_d = top_idx;
               cnt_d  = cnt_q - 1'b1;
            end
         end
         OP_SWAP: begin
            wr_en_o = 1'b1;
            if (empty_o) begin
               underflow_o = 1'b1;
               wptr_d      = wrap_inc(wptr_q);
               cnt_d       = CNT_W'(1);
            end else begin
               wr_idx_o = top_idx;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         wptr_q <= wptr_d;
         cnt_q  <= cnt_d;
      end
   end

   assign rd_idx_o = top_idx;
   assign count_o  = cnt_q;

endmodule

// File: rtl/rs_irq_gate.sv
module rs_irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic en_i,
   input  logic room_i,
   input  logic busy_i,
   output logic ack_o
);

   logic pend_q;

   assign ack_o = pend_q && en_i && room_i && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= (pend_q && !ack_o) || req_i;
      end
   end

endmodule

// File: rtl/ret_stack_irq_gate.sv
module ret_stack_irq_gate #(
   parameter int unsigned ADDR_W         = 11,
   parameter int unsigned DEPTH          = 6,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              irq_req_i,
   input  logic              irq_en_i,
   output logic [ADDR_W-1:0] ret_addr_o,
   output logic              irq_ack_o,
   output logic              full_o,
   output logic              empty_o,
   output logic              underflow_o
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ret_stack_irq_gate: DEPTH must be at least 2");
   end
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
      $error("ret_stack_irq_gate: ADDR_W must be 1..32");
   end

   logic             push_any;
   logic             wr_en;
   logic [PTR_W-1:0] wr_idx;
   logic [PTR_W-1:0] rd_idx;
   logic [CNT_W-1:0] occ;

   rs_irq_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (irq_req_i),
      .en_i   (irq_en_i),
      .room_i (!full_o),
      .busy_i (call_i || ret_i),
      .ack_o  (irq_ack_o)
   );

   assign push_any = call_i || irq_ack_o;

   rs_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_any),
      .pop_i       (ret_i),
      .wr_en_o     (wr_en),
      .wr_idx_o    (wr_idx),
      .rd_idx_o    (rd_idx),
      .count_o     (occ),
      .full_o      (full_o),
      .empty_o     (empty_o),
      .underflow_o (underflow_o)
   );

   rs_store #(
      .ADDR_W         (ADDR_W),
      .DEPTH          (DEPTH),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (pc_i),
      .rd_idx_i  (rd_idx),
      .rd_data_o (ret_addr_o)
   );

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
   parameter int unsigned DEPTH  = 6,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             call_i,
   input logic             ret_i,
   input logic             irq_req_i,
   input logic             irq_en_i,
   input logic             irq_ack_o,
   input logic             full_o,
   input logic             empty_o,
   input logic             underflow_o,
   input logic [CNT_W-1:0] occ
);

   AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH)); // R3
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o)); // R3
   AST_CALL_ON_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && call_i && !ret_i) |=> full_o); // R4
   AST_UNDERFLOW_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_o |-> (empty_o && ret_i)); // R5
   AST_EMPTY_POP_STAYS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && ret_i && !call_i) |=> empty_o); // R5
   AST_POP_LEAVES_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_o && ret_i && !call_i) |=> !full_o); // R5
   AST_ACK_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_o |-> (!full_o && irq_en_i && !call_i && !ret_i)); // R6
   AST_ACK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_o && !irq_req_i) |=> !irq_ack_o); // R7
   AST_ACK_GROWS_STACK: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_o |=> !empty_o); // R7

endmodule

bind ret_stack_irq_gate rs_checker #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .call_i      (call_i),
   .ret_i       (ret_i),
   .irq_req_i   (irq_req_i),
   .irq_en_i    (irq_en_i),
   .irq_ack_o   (irq_ack_o),
   .full_o      (full_o),
   .empty_o     (empty_o),
   .underflow_o (underflow_o),
   .occ         (occ)
);

// File: tb/ret_stack_irq_gate_tb.sv
module ret_stack_irq_gate_tb;

   localparam int AW    = 11;
   localparam int DEPTH = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          call_i = 1'b0;
   logic          ret_i = 1'b0;
   logic [AW-1:0] pc_i = '0;
   logic          irq_req_i = 1'b0;
   logic          irq_en_i = 1'b0;
   logic [AW-1:0] ret_addr_o;
   logic          irq_ack_o;
   logic          full_o;
   logic          empty_o;
   logic          underflow_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // behavioural reference
   logic [AW-1:0] mq[$];
   bit            m_pend = 1'b0;

   always #2 clk = ~clk;

   ret_stack_irq_gate #(.ADDR_W(AW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .pc_i(pc_i),
      .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .ret_addr_o(ret_addr_o),
      .irq_ack_o(irq_ack_o), .full_o(full_o), .empty_o(empty_o),
      .underflow_o(underflow_o)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input string tag, input bit c, input bit r, input bit q,
                       input bit e, input logic [AW-1:0] pc);
      bit x_full, x_empty, x_ack, x_unf;
      @(negedge clk);
      call_i = c; ret_i = r; irq_req_i = q; irq_en_i = e; pc_i = pc;
      #1;
      x_full  = (mq.size() == DEPTH);
      x_empty = (mq.size() == 0);
      x_ack   = m_pend && e && !x_full && !c && !r;
      x_unf   = r && x_empty;
      chk(tag, "full_o", 32'(full_o), 32'(x_full));
      chk(tag, "empty_o", 32'(empty_o), 32'(x_empty));
      chk(tag, "irq_ack_o", 32'(irq_ack_o), 32'(x_ack));
      chk(tag, "underflow_o", 32'(underflow_o), 32'(x_unf));
      if (r && !x_empty) chk(tag, "ret_addr_o", 32'(ret_addr_o), 32'(mq[$]));
      @(posedge clk);
      if (r && (c || x_ack)) begin
         if (x_empty) mq.push_back(pc);
         else mq[mq.size()-1] = pc;
      end else if (c || x_ack) begin
         if (x_full) void'(mq.pop_front());
         mq.push_back(pc);
      end else if (r && !x_empty) begin
         void'(mq.pop_back());
      end
      m_pend = (m_pend && !x_ack) || q;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "empty_o in reset", 32'(empty_o), 32'd1);
      chk("R1", "full_o in reset", 32'(full_o), 32'd0);
      rst_n = 1'b1;
      // R1: enabled but nothing requested
      for (int i = 0; i < 3; i++) step("R1", 0, 0, 0, 1, '0);
      // R2: push three, pop three
      step("R2", 1, 0, 0, 0, 11'h101);
      step("R2", 1, 0, 0, 0, 11'h202);
      step("R2", 1, 0, 0, 0, 11'h303);
      for (int i = 0; i < 3; i++) step("R2", 0, 1, 0, 0, '0);
      // R5: pop on empty
      step("R5", 0, 1, 0, 0, '0);
      step("R5", 0, 1, 0, 0, '0);
      step("R5", 0, 0, 0, 0, '0);
      // R3/R4: fill then overflow twice, drain all
      for (int i = 0; i < DEPTH; i++) step("R3", 1, 0, 0, 0, 11'(16 + i));
      step("R4", 1, 0, 0, 0, 11'h7A1);
      step("R4", 1, 0, 0, 0, 11'h7A2);
      for (int i = 0; i < DEPTH + 1; i++) step("R4", 0, 1, 0, 0, '0);
      // R6/R7: interrupt on an empty stack
      step("R6", 0, 0, 1, 1, 11'h055);
      step("R7", 0, 0, 0, 1, 11'h066);
      step("R7", 0, 0, 0, 1, 11'h077);
      step("R7", 0, 1, 0, 1, '0);
      // R7: request again in acknowledge cycle
      step("R7", 0, 0, 1, 1, 11'h011);
      step("R7", 0, 0, 1, 1, 11'h022);
      step("R7", 0, 0, 0, 1, 11'h033);
      step("R7", 0, 0, 0, 1, 11'h044);
      for (int i = 0; i < 3; i++) step("R7", 0, 1, 0, 0, '0);
      // R6: call blocks acknowledge in its cycle
      step("R6", 0, 0, 1, 1, '0);
      step("R6", 1, 0, 0, 1, 11'h123);
      step("R6", 0, 0, 0, 1, 11'h124);
      step("R6", 0, 1, 0, 0, '0);
      step("R6", 0, 1, 0, 0, '0);
      // R10: masked request stays pending
      step("R10", 0, 0, 1, 0, '0);
      for (int i = 0; i < 3; i++) step("R10", 0, 0, 0, 0, 11'h3F0);
      step("R10", 0, 0, 0, 1, 11'h3F1);
      step("R10", 0, 1, 0, 0, '0);
      // R8: request held off while full
      for (int i = 0; i < DEPTH; i++) step("R8", 1, 0, 0, 1, 11'(32 + i));
      step("R8", 0, 0, 1, 1, 11'h500);
      step("R8", 0, 0, 0, 1, 11'h501);
      step("R8", 0, 0, 0, 1, 11'h502);
      step("R8", 0, 1, 0, 1, '0);
      step("R8", 0, 0, 0, 1, 11'h5AA);
      for (int i = 0; i < DEPTH + 1; i++) step("R8", 0, 1, 0, 0, '0);
      // R9: simultaneous call and pop
      step("R9", 1, 1, 0, 0, 11'h0C1);
      step("R9", 1, 0, 0, 0, 11'h0C2);
      step("R9", 1, 1, 0, 0, 11'h0C3);
      step("R9", 0, 1, 0, 0, '0);
      step("R9", 0, 1, 0, 0, '0);
      step("R9", 0, 1, 0, 0, '0);
      // mixed traffic against the reference queue
      for (int i = 0; i < 600; i++)
         step("R2", ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 7) == 0,
              ($urandom % 4) != 0, 11'($urandom));
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule